// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block is an 8-port self-routing interconnect made of three columns of 2x2 switching elements. A fixed perfect-shuffle wiring stands in front of every column. Each input port offers a packet: a valid flag, a 3-bit destination port number and a data word. Every element sets itself from one bit of the destination of the packet on its upper input (or its lower input when the upper one is idle). It either passes its inputs straight through or crosses them over.

Because the network is not a crossbar, two packets of an otherwise legal permutation can claim the same internal link. The block resolves such a conflict in the same cycle. It delivers the packet that arrived on the element's upper input, drops the other one and reports the drop on a per-source blocked flag. Nothing is buffered or retried. Results are registered and appear one clock after the inputs are sampled.

Top module: `omega_net`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every `out_valid` bit and every `blocked` bit at that edge, whatever the inputs are.
- R2: A packet sampled at rising edge N appears at the outputs right after edge N. The outputs are fully replaced at every edge, so back-to-back input patterns each produce their own result one cycle later.
- R3: A delivered packet appears on output port `d`, where `d` is its destination tag. `out_data[d]` carries its data word and `out_src[d]` carries its input port number (0 to 7).
- R4: Routing is set column by column. Before column k (k = 0, 1, 2), link i moves to position rotate-left-by-one(i) of the 3-bit index. Positions 2m (upper) and 2m+1 (lower) feed element m. A packet leaves the element on position 2m + b, where b is destination bit 2-k.
- R5: When both inputs of an element need the same output, the upper-input packet wins. The lower one is dropped, and `blocked[s]` is set for its source port s. For example, sources 2→7 and 6→4 presented together deliver source 2 on port 7 and set `blocked[6]`.
- R6: When all eight inputs are valid and every pair has the same value of source XOR destination, all eight packets are delivered and no `blocked` bit is set.
- R7: An input with `in_valid` low produces no output and no `blocked` bit, whatever its destination and data.
- R8: When several packets target one destination, exactly one of them is delivered, and every other one has its `blocked` bit set.
- R9: Each valid input ends up either delivered on exactly one port or flagged in `blocked`, never both. Flags do not persist: an idle cycle clears all `out_valid` and `blocked` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 8 | Per-port packet present flag |
| in_dest | input | 8x3 | Per-port destination port number |
| in_data | input | 8x8 | Per-port data word |
| out_valid | output | 8 | Per-port delivered packet flag (registered) |
| out_data | output | 8x8 | Data word of the delivered packet |
| out_src | output | 8x3 | Input port the delivered packet came from |
| blocked | output | 8 | Per-source flag: this source's packet was dropped by contention |

## Verification
Every result of this block is due exactly one rising edge after the inputs are sampled. This covers the delivered packets on `out_*`, the per-source `blocked` flags and the reset clearing. The driver applies a pattern on a falling edge and queues its expected result. The monitor pops that entry one nanosecond after the next rising edge, so each comparison lands in the single cycle the pattern owns. Back-to-back patterns, including an idle cycle right after a contention pattern, show that nothing leaks into the following cycle.

// File: rtl/omega_pkg.sv
// Package: shared definitions for the omega network.
// Assumes port counts are powers of two; index rotation is on TAG_W bits.
package omega_pkg;

    // Setting of one 2x2 switching element.
    typedef enum logic {
        SW_PASS  = 1'b0,
        SW_CROSS = 1'b1
    } sw_mode_e;

    // Rotate a w-bit index left by one position (perfect shuffle).
    function automatic int rotl1(input int v, input int w);
        int mask;
        mask = (1 << w) - 1;
        return ((v << 1) | (v >> (w - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_shuffle.sv
// omega_shuffle: pure wiring; link i is moved to position rotl1(i).
// Assumes PORTS == 2**TAG_W. No logic, no state.
module omega_shuffle #(
    parameter int PORTS = 8,
    parameter int TAG_W = 3,
    parameter int PW    = 15
) (
    input  logic [PORTS-1:0][PW-1:0] link_in,
    output logic [PORTS-1:0][PW-1:0] link_out
);
    import omega_pkg::*;

    // Each input link is assigned to exactly one shuffled position.
    for (genvar i = 0; i < PORTS; i++) begin : g_wire
        assign link_out[rotl1(i, TAG_W)] = link_in[i];
    end

endmodule

// File: rtl/omega_switch.sv
// omega_switch: one 2x2 element. Packet layout (MSB first):
// {valid, src[TAG_W], dest[TAG_W], data[DATA_W]}.
// The element is set from the upper packet if valid, else the lower one;
// the wanted output is destination bit SEL_BIT. A lower packet whose
// wanted output is taken by the upper packet is dropped and reported.
module omega_switch #(
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 8,
    parameter int SEL_BIT = 2,
    localparam int PW     = 1 + 2 * TAG_W + DATA_W
) (
    input  logic [PW-1:0]    pkt_up,
    input  logic [PW-1:0]    pkt_lo,
    output logic [PW-1:0]    pkt_even,
    output logic [PW-1:0]    pkt_odd,
    output logic             drop_vld,
    output logic [TAG_W-1:0] drop_src
);
    import omega_pkg::*;

    localparam int VLD_POS  = PW - 1;
    localparam int SRC_LSB  = TAG_W + DATA_W;
    localparam int DEST_LSB = DATA_W;

    logic     up_v, lo_v, up_want, lo_want;
    sw_mode_e mode;
    logic [PW-1:0] route_even, route_odd;

    assign up_v    = pkt_up[VLD_POS];
    assign lo_v    = pkt_lo[VLD_POS];
    assign up_want = pkt_up[DEST_LSB + SEL_BIT];
    assign lo_want = pkt_lo[DEST_LSB + SEL_BIT];

    // Pick the element setting; the upper packet has priority.
    always_comb begin
        if (up_v) mode = up_want ? SW_CROSS : SW_PASS;
        else      mode = lo_want ? SW_PASS  : SW_CROSS;
    end

    // Steer both inputs according to the setting.
    always_comb begin
        if (mode == SW_PASS) begin
            route_even = pkt_up;
            route_odd  = pkt_lo;
        end else begin
            route_even = pkt_lo;
            route_odd  = pkt_up;
        end
    end

    // Conflict: lower packet wants the output the upper packet took.
    assign drop_vld = up_v && lo_v && (up_want == lo_want);
    assign drop_src = pkt_lo[SRC_LSB +: TAG_W];

    // Suppress the misrouted loser so it never reaches a later column.
    always_comb begin
        pkt_even = route_even;
        pkt_odd  = route_odd;
        if (drop_vld) begin
            if (up_want) pkt_even[VLD_POS] = 1'b0;
            else         pkt_odd[VLD_POS]  = 1'b0;
        end
    end

endmodule

// File: rtl/omega_stage.sv
// omega_stage: one column = perfect shuffle followed by PORTS/2 elements.
// Column STAGE_IDX steers on destination bit TAG_W-1-STAGE_IDX.
// drop_mask is indexed by the original source port of dropped packets.
module omega_stage #(
    parameter int PORTS     = 8,
    parameter int TAG_W     = 3,
    parameter int DATA_W    = 8,
    parameter int STAGE_IDX = 0,
    localparam int PW       = 1 + 2 * TAG_W + DATA_W,
    localparam int HALF     = PORTS / 2
) (
    input  logic [PORTS-1:0][PW-1:0] stage_in,
    output logic [PORTS-1:0][PW-1:0] stage_out,
    output logic [PORTS-1:0]         drop_mask
);
    logic [PORTS-1:0][PW-1:0]  shuffled;
    logic [HALF-1:0]           el_drop;
    logic [HALF-1:0][TAG_W-1:0] el_src;

    omega_shuffle #(.PORTS(PORTS), .TAG_W(TAG_W), .PW(PW)) u_shuffle (
        .link_in  (stage_in),
        .link_out (shuffled)
    );

    for (genvar m = 0; m < HALF; m++) begin : g_el
        omega_switch #(.TAG_W(TAG_W), .DATA_W(DATA_W),
                       .SEL_BIT(TAG_W - 1 - STAGE_IDX)) u_sw (
            .pkt_up   (shuffled[2*m]),
            .pkt_lo   (shuffled[2*m+1]),
            .pkt_even (stage_out[2*m]),
            .pkt_odd  (stage_out[2*m+1]),
            .drop_vld (el_drop[m]),
            .drop_src (el_src[m])
        );
    end

    // Decode each element's drop report into a per-source mask.
    always_comb begin
        drop_mask = '0;
        for (int m = 0; m < HALF; m++) begin
            if (el_drop[m]) drop_mask[el_src[m]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_net.sv
// omega_net: PORTS-port omega network of log2(PORTS) columns.
// Tags each packet with its source port, routes it combinationally
// through all columns, and registers delivered packets and per-source
// blocked flags. Assumes PORTS is a power of two, >= 2.
module omega_net #(
    parameter int PORTS  = 8,
    parameter int DATA_W = 8,
    localparam int TAG_W  = $clog2(PORTS),
    localparam int STAGES = TAG_W,
    localparam int PW     = 1 + 2 * TAG_W + DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PORTS-1:0]              in_valid,
    input  logic [PORTS-1:0][TAG_W-1:0]   in_dest,
    input  logic [PORTS-1:0][DATA_W-1:0]  in_data,
    output logic [PORTS-1:0]              out_valid,
    output logic [PORTS-1:0][DATA_W-1:0]  out_data,
    output logic [PORTS-1:0][TAG_W-1:0]   out_src,
    output logic [PORTS-1:0]              blocked
);
    localparam int SRC_LSB = TAG_W + DATA_W;

    logic [STAGES:0][PORTS-1:0][PW-1:0] col_pkt;
    logic [STAGES-1:0][PORTS-1:0]       col_drop;
    logic [PORTS-1:0]                   drop_any;

    // Build packets with the source port number attached.
    for (genvar i = 0; i < PORTS; i++) begin : g_pack
        assign col_pkt[0][i] = {in_valid[i], TAG_W'(i), in_dest[i], in_data[i]};
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_col
        omega_stage #(.PORTS(PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W),
                      .STAGE_IDX(k)) u_stage (
            .stage_in  (col_pkt[k]),
            .stage_out (col_pkt[k+1]),
            .drop_mask (col_drop[k])
        );
    end

    // Merge drop reports of all columns.
    always_comb begin
        drop_any = '0;
        for (int k = 0; k < STAGES; k++) drop_any |= col_drop[k];
    end

    // Register the delivered packets and blocked flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            blocked   <= '0;
            out_data  <= '0;
            out_src   <= '0;
        end else begin
            blocked <= drop_any;
            for (int j = 0; j < PORTS; j++) begin
                out_valid[j] <= col_pkt[STAGES][j][PW-1];
                out_src[j]   <= col_pkt[STAGES][j][SRC_LSB +: TAG_W];
                out_data[j]  <= col_pkt[STAGES][j][DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/omega_net_chk.sv
// omega_net_chk: protocol checker bound to omega_net. Keeps its own copy
// of the previous cycle's inputs and relates it to the registered outputs.
module omega_net_chk #(
    parameter int PORTS  = 8,
    parameter int DATA_W = 8,
    localparam int TAG_W = $clog2(PORTS),
    localparam int CW    = $clog2(PORTS + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [PORTS-1:0]              in_valid,
    input logic [PORTS-1:0][TAG_W-1:0]   in_dest,
    input logic [PORTS-1:0][DATA_W-1:0]  in_data,
    input logic [PORTS-1:0]              out_valid,
    input logic [PORTS-1:0][DATA_W-1:0]  out_data,
    input logic [PORTS-1:0][TAG_W-1:0]   out_src,
    input logic [PORTS-1:0]              blocked
);
    logic                        armed = 1'b0;
    logic                        was_rst = 1'b0;
    logic [PORTS-1:0]            p_valid;
    logic [PORTS-1:0][TAG_W-1:0] p_dest;
    logic                        p_uniform;
    logic                        uniform_now;
    logic [PORTS-1:0][CW-1:0]    hits;

    // Is every port valid with one common source XOR destination?
    always_comb begin
        uniform_now = &in_valid;
        for (int i = 0; i < PORTS; i++) begin
            if ((in_dest[i] ^ TAG_W'(i)) != in_dest[0]) uniform_now = 1'b0;
        end
    end

    // Remember the inputs the outputs must answer for.
    always_ff @(posedge clk) begin
        armed     <= 1'b1;
        was_rst   <= !rst_n;
        p_valid   <= rst_n ? in_valid : '0;
        p_dest    <= in_dest;
        p_uniform <= rst_n && uniform_now;
    end

    // Count on how many output ports each source is delivered.
    always_comb begin
        hits = '0;
        for (int i = 0; i < PORTS; i++) begin
            for (int j = 0; j < PORTS; j++) begin
                if (out_valid[j] && out_src[j] == TAG_W'(i)) hits[i] = hits[i] + 1'b1;
            end
        end
    end

    // R1: an edge with reset low leaves no valid or blocked flag.
    assert_reset_clear_R1: assert property (@(posedge clk)
        (armed && was_rst) |-> (out_valid == '0 && blocked == '0));

    for (genvar j = 0; j < PORTS; j++) begin : g_port
        // R3: a delivered packet sits on its destination port and came from a valid input.
        assert_dest_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && out_valid[j]) |-> (p_valid[out_src[j]] && p_dest[out_src[j]] == TAG_W'(j)));
    end

    for (genvar i = 0; i < PORTS; i++) begin : g_src
        // R9: each valid source is delivered once or blocked, not both.
        assert_conserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && p_valid[i]) |-> ((32'(hits[i]) + 32'(blocked[i])) == 1));
        // R7: an idle source leaves no trace.
        assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !p_valid[i]) |-> (hits[i] == '0 && !blocked[i]));
    end

    // R6: a uniform-XOR full permutation passes untouched.
    assert_uniform_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && p_uniform) |-> (blocked == '0 && &out_valid));

endmodule

bind omega_net omega_net_chk #(.PORTS(PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/omega_net_tb.sv
// Scoreboard bench: the driver applies a pattern on a falling edge and
// queues the expected result; the monitor checks it after the next rising edge.
module omega_net_tb;
    localparam int P  = 8;
    localparam int TW = 3;
    localparam int DW = 8;

    typedef struct {
        logic [P-1:0]          ov;
        logic [P-1:0][DW-1:0]  od;
        logic [P-1:0][TW-1:0]  os;
        logic [P-1:0]          blk;
        string                 tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [P-1:0]          in_valid = '0;
    logic [P-1:0][TW-1:0]  in_dest = '0;
    logic [P-1:0][DW-1:0]  in_data = '0;
    logic [P-1:0]          out_valid;
    logic [P-1:0][DW-1:0]  out_data;
    logic [P-1:0][TW-1:0]  out_src;
    logic [P-1:0]          blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    omega_net #(.PORTS(P), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_src(out_src), .blocked(blocked)
    );

    // Expected result from R3/R4/R5/R7: trace link occupancy column by column.
    function automatic exp_t model(input logic [P-1:0] v, input logic [P-1:0][TW-1:0] d,
                                   input logic [P-1:0][DW-1:0] dat, input string tag);
        exp_t e;
        int occ[P];
        int nxt[P];
        int shf[P];
        e.ov = '0; e.od = '0; e.os = '0; e.blk = '0; e.tag = tag;
        for (int i = 0; i < P; i++) occ[i] = v[i] ? i : -1;
        for (int k = 0; k < TW; k++) begin
            for (int i = 0; i < P; i++) shf[((i << 1) | (i >> (TW - 1))) & (P - 1)] = occ[i];
            for (int i = 0; i < P; i++) nxt[i] = -1;
            for (int m = 0; m < P / 2; m++) begin
                int u, l, bu, bl;
                u = shf[2*m]; l = shf[2*m+1];
                bu = (u >= 0) ? int'(d[u][TW-1-k]) : 0;
                bl = (l >= 0) ? int'(d[l][TW-1-k]) : 0;
                if (u >= 0) nxt[2*m + bu] = u;
                if (l >= 0) begin
                    if (u >= 0 && bu == bl) e.blk[l] = 1'b1;
                    else nxt[2*m + bl] = l;
                end
            end
            for (int i = 0; i < P; i++) occ[i] = nxt[i];
        end
        for (int j = 0; j < P; j++) begin
            if (occ[j] >= 0) begin
                e.ov[j] = 1'b1;
                e.od[j] = dat[occ[j]];
                e.os[j] = TW'(occ[j]);
            end
        end
        return e;
    endfunction

    // Driver: apply one pattern and queue what it must produce.
    task automatic drive(input bit rst, input logic [P-1:0] v,
                         input logic [P-1:0][TW-1:0] d, input string tag);
        logic [P-1:0][DW-1:0] dat;
        exp_t e;
        @(negedge clk);
        for (int i = 0; i < P; i++) dat[i] = DW'($urandom);
        rst_n = !rst; in_valid = v; in_dest = d; in_data = dat;
        if (rst) begin
            e.ov = '0; e.od = '0; e.os = '0; e.blk = '0; e.tag = tag;
        end else begin
            e = model(v, d, dat, tag);
        end
        exp_q.push_back(e);
    endtask

    // Monitor: compare one queued result one nanosecond after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (out_valid !== e.ov) begin
                    errors++;
                    $display("FAIL %s out_valid actual=%b expected=%b", e.tag, out_valid, e.ov);
                end
                checks++;
                if (blocked !== e.blk) begin
                    errors++;
                    $display("FAIL %s blocked actual=%b expected=%b", e.tag, blocked, e.blk);
                end
                for (int j = 0; j < P; j++) begin
                    if (e.ov[j]) begin
                        checks++;
                        if (out_data[j] !== e.od[j] || out_src[j] !== e.os[j]) begin
                            errors++;
                            $display("FAIL %s port %0d data/src actual=%h/%0d expected=%h/%0d",
                                     e.tag, j, out_data[j], out_src[j], e.od[j], e.os[j]);
                        end
                    end
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        logic [P-1:0][TW-1:0] d;
        // R1: reset with every input valid.
        for (int i = 0; i < P; i++) d[i] = TW'(i);
        drive(1'b1, '1, d, "R1");
        drive(1'b1, '1, d, "R1");
        // R6: identity, complement and XOR-3 permutations.
        drive(1'b0, '1, d, "R6");
        for (int i = 0; i < P; i++) d[i] = ~TW'(i);
        drive(1'b0, '1, d, "R6");
        for (int i = 0; i < P; i++) d[i] = TW'(i) ^ 3'd3;
        drive(1'b0, '1, d, "R6");
        // R3: each single source to each destination.
        for (int s = 0; s < P; s++) begin
            for (int t = 0; t < P; t++) begin
                d = '0; d[s] = TW'(t);
                drive(1'b0, P'(1) << s, d, "R3");
            end
        end
        // R5: 2->7 with 6->4, source 6 must be blocked.
        d = '0; d[2] = 3'd7; d[6] = 3'd4;
        drive(1'b0, 8'b0100_0100, d, "R5");
        // R9: idle cycle right after contention clears all flags.
        drive(1'b0, '0, d, "R9");
        // R8: all eight sources to destination 5.
        for (int i = 0; i < P; i++) d[i] = 3'd5;
        drive(1'b0, '1, d, "R8");
        // R7: invalid inputs carry colliding tags but must vanish.
        for (int i = 0; i < P; i++) d[i] = 3'd1;
        drive(1'b0, 8'b0000_0001, d, "R7");
        // R2: back-to-back distinct patterns.
        for (int i = 0; i < P; i++) d[i] = TW'(P - 1 - i);
        drive(1'b0, '1, d, "R2");
        for (int i = 0; i < P; i++) d[i] = TW'(i + 1);
        drive(1'b0, 8'b1010_0110, d, "R2");
        // R4: random patterns exercising column settings and contention.
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < P; i++) d[i] = TW'($urandom);
            drive(1'b0, P'($urandom), d, "R4");
        end
        // R1: reset again mid-run.
        drive(1'b1, '1, d, "R1");
        drive(1'b0, '0, d, "R9");
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule